// File: doc/BRIEF.md
# Reading Latch with Peak and Freeze Control

This block sits between a measurement engine (a dual-slope converter or a frequency counter) and the display decoder. Each finished measurement arrives as a one-cycle strobe with a signed two's-complement reading and an overload flag. The block produces an active-low end-of-measurement pulse and decides whether the reading replaces the value held for display.

There are three ways the display can be updated. In normal operation every reading is shown. In peak mode, a reading is shown only if its magnitude is larger than the magnitude already shown, so the largest reading is kept and never decays. While the freeze input is high, the shown value does not change, but measurements carry on. Range status outputs are refreshed on every measurement. An external range selector can use them to switch ranges: one flag marks a reading too small to use, the other marks an overload.

Top module: `disp_hold_reg`

## Requirements
- R1: After a cycle with `res_valid_i` high, `eoc_n_o` is low for exactly `EOC_LEN` (default 10) cycles, starting at the next clock edge. Outside such a window it is high.
- R2: In normal operation (`hold_i` low, `peak_en_i` low), a reading is loaded at the edge that ends its strobe cycle. `disp_value_o` takes the reading and `disp_ovr_o` goes low.
- R3: While `hold_i` is high in the strobe cycle, `disp_value_o` and `disp_ovr_o` keep their values. The end-of-measurement pulse and the range flags still update.
- R4: With `peak_en_i` high, a reading is loaded only if its magnitude is strictly greater than the magnitude shown. A reading of equal magnitude is ignored even if its sign differs. A loaded reading keeps its sign.
- R5: When `peak_en_i` rises, the value already shown is the starting peak. After `peak_en_i` falls, the next reading loads as in normal operation.
- R6: A reading is an overload when `res_ovr_i` is high or its magnitude exceeds `FULL_SCALE` (default 3999). When an overload is loaded, `disp_ovr_o` is 1 and `disp_value_o` is 0. In peak mode an overload beats any numeric reading, and nothing beats a shown overload.
- R7: `under_o` is 1 after a reading that is not an overload and whose magnitude is at most `UNDER_LIMIT` (default 380). For example, 380 and -380 give 1 and 381 gives 0. `over_o` is 1 after an overload reading.
- R8: `under_o` and `over_o` are set by every reading, whatever `hold_i` and `peak_en_i` are. They keep their values between readings.
- R9: While `rst_n` is low, `disp_value_o` is 0, `disp_ovr_o` is 0, `eoc_n_o` is 1, and `under_o` and `over_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid_i | input | 1 | One-cycle strobe: a new reading is present |
| res_value_i | input | WIDTH | Signed two's-complement reading |
| res_ovr_i | input | 1 | Engine reports overload for this reading |
| hold_i | input | 1 | Freeze the shown value |
| peak_en_i | input | 1 | Keep the largest-magnitude reading |
| disp_value_o | output | WIDTH | Shown reading, signed |
| disp_ovr_o | output | 1 | Shown reading is the overload code |
| eoc_n_o | output | 1 | Active-low end-of-measurement pulse |
| under_o | output | 1 | Last reading at or below the under-range limit |
| over_o | output | 1 | Last reading was an overload |

## Verification
The assertions assume that `res_valid_i` pulses are at least `EOC_LEN + 1` cycles apart, as they are from a real measurement engine. They also assume that `hold_i` and `peak_en_i` change only between readings. The stimulus keeps to this by sending one strobe and then waiting twelve idle cycles. It changes the mode inputs only during those gaps. The readings are chosen to hit the equal-magnitude, sign-flip, 380/381 and 3999/4000 boundaries.

// File: rtl/disp_hold_pkg.sv
package disp_hold_pkg;
    localparam int DH_WIDTH_DEF = 13;
    localparam int DH_FULL_DEF  = 3999;
    localparam int DH_UNDER_DEF = 380;
    localparam int DH_EOC_DEF   = 10;

    typedef enum logic [1:0] {
        LD_NONE   = 2'd0,
        LD_NORMAL = 2'd1,
        LD_PEAK   = 2'd2
    } load_kind_e;
endpackage

// File: rtl/dh_magnitude.sv
module dh_magnitude #(
    parameter int WIDTH = 13
) (
    input  logic signed [WIDTH-1:0] value_i,
    output logic        [WIDTH-1:0] mag_o
);
    always_comb begin
        if (value_i[WIDTH-1])
            mag_o = WIDTH'(0 - value_i);
        else
            mag_o = WIDTH'(value_i);
    end
endmodule

// File: rtl/dh_eoc_timer.sv
module dh_eoc_timer #(
    parameter int EOC_LEN = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic eoc_n_o
);
    localparam int CW = $clog2(EOC_LEN + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i)
            st_d.cnt = CW'(EOC_LEN);
        else if (st_q.cnt != '0)
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign eoc_n_o = (st_q.cnt == '0);
endmodule

// File: rtl/disp_hold_reg.sv
module disp_hold_reg
    import disp_hold_pkg::*;
#(
    parameter int WIDTH       = DH_WIDTH_DEF,
    parameter int FULL_SCALE  = DH_FULL_DEF,
    parameter int UNDER_LIMIT = DH_UNDER_DEF,
    parameter int EOC_LEN     = DH_EOC_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    res_valid_i,
    input  logic signed [WIDTH-1:0] res_value_i,
    input  logic                    res_ovr_i,
    input  logic                    hold_i,
    input  logic                    peak_en_i,
    output logic signed [WIDTH-1:0] disp_value_o,
    output logic                    disp_ovr_o,
    output logic                    eoc_n_o,
    output logic                    under_o,
    output logic                    over_o
);
    localparam logic [WIDTH-1:0] FULL_MAG  = WIDTH'(FULL_SCALE);
    localparam logic [WIDTH-1:0] UNDER_MAG = WIDTH'(UNDER_LIMIT);

    typedef struct packed {
        logic signed [WIDTH-1:0] val;
        logic                    ovr;
        logic                    under;
        logic                    over;
    } disp_state_t;

    disp_state_t st_d, st_q;

    logic [WIDTH-1:0] new_mag;
    logic [WIDTH-1:0] shown_mag;
    logic             new_is_ovr;
    logic             new_bigger;
    load_kind_e       load_kind;

    dh_magnitude #(.WIDTH(WIDTH)) u_mag_new (
        .value_i (res_value_i),
        .mag_o   (new_mag)
    );

    dh_magnitude #(.WIDTH(WIDTH)) u_mag_shown (
        .value_i (st_q.val),
        .mag_o   (shown_mag)
    );

    dh_eoc_timer #(.EOC_LEN(EOC_LEN)) u_eoc (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (res_valid_i),
        .eoc_n_o (eoc_n_o)
    );

    always_comb begin
        new_is_ovr = res_ovr_i || (new_mag > FULL_MAG);
        if (st_q.ovr)
            new_bigger = 1'b0;
        else if (new_is_ovr)
            new_bigger = 1'b1;
        else
            new_bigger = (new_mag > shown_mag);

        if (!res_valid_i || hold_i)
            load_kind = LD_NONE;
        else if (!peak_en_i)
            load_kind = LD_NORMAL;
        else if (new_bigger)
            load_kind = LD_PEAK;
        else
            load_kind = LD_NONE;
    end

    always_comb begin
        st_d = st_q;
        if (res_valid_i) begin
            st_d.over  = new_is_ovr;
            st_d.under = !new_is_ovr && (new_mag <= UNDER_MAG);
        end
        if (load_kind != LD_NONE) begin
            st_d.ovr = new_is_ovr;
            st_d.val = new_is_ovr ? '0 : res_value_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign disp_value_o = st_q.val;
    assign disp_ovr_o   = st_q.ovr;
    assign under_o      = st_q.under;
    assign over_o       = st_q.over;
endmodule

// File: rtl/disp_hold_checker.sv
module disp_hold_checker #(
    parameter int WIDTH   = 13,
    parameter int EOC_LEN = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    res_valid_i,
    input logic                    hold_i,
    input logic                    peak_en_i,
    input logic signed [WIDTH-1:0] disp_value_o,
    input logic                    disp_ovr_o,
    input logic                    eoc_n_o,
    input logic                    under_o,
    input logic                    over_o
);
    localparam int CW = $clog2(EOC_LEN + 2);

    logic [CW-1:0]    low_run;
    logic [WIDTH-1:0] shown_mag;

    always_ff @(posedge clk) begin
        if (!rst_n)
            low_run <= '0;
        else if (!eoc_n_o && low_run <= CW'(EOC_LEN))
            low_run <= low_run + 1'b1;
        else if (eoc_n_o)
            low_run <= '0;
    end

    always_comb begin
        if (disp_value_o[WIDTH-1])
            shown_mag = WIDTH'(0 - disp_value_o);
        else
            shown_mag = WIDTH'(disp_value_o);
    end

    p_eoc_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !eoc_n_o |-> (low_run < CW'(EOC_LEN)));

    p_eoc_starts_r1: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_i |=> !eoc_n_o);

    p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid_i |=> ($stable(disp_value_o) && $stable(disp_ovr_o)
                          && $stable(under_o) && $stable(over_o)));

    p_hold_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_i && hold_i) |=> ($stable(disp_value_o) && $stable(disp_ovr_o)));

    p_peak_no_shrink_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (peak_en_i && !disp_ovr_o) |=> (disp_ovr_o || shown_mag >= $past(shown_mag)));

    p_peak_ovr_sticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (peak_en_i && disp_ovr_o) |=> disp_ovr_o);

    p_ovr_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        disp_ovr_o |-> (disp_value_o == '0));

    p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(under_o && over_o));
endmodule

bind disp_hold_reg disp_hold_checker #(.WIDTH(WIDTH), .EOC_LEN(EOC_LEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .res_valid_i  (res_valid_i),
    .hold_i       (hold_i),
    .peak_en_i    (peak_en_i),
    .disp_value_o (disp_value_o),
    .disp_ovr_o   (disp_ovr_o),
    .eoc_n_o      (eoc_n_o),
    .under_o      (under_o),
    .over_o       (over_o)
);

// File: tb/test_disp_hold_reg.sv
module test_disp_hold_reg;
    localparam int W = 13;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                res_valid_i = 1'b0;
    logic signed [W-1:0] res_value_i = '0;
    logic                res_ovr_i = 1'b0;
    logic                hold_i = 1'b0;
    logic                peak_en_i = 1'b0;
    logic signed [W-1:0] disp_value_o;
    logic                disp_ovr_o;
    logic                eoc_n_o;
    logic                under_o;
    logic                over_o;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    int  m_val = 0;
    bit  m_ovr = 0;
    bit  m_under = 0;
    bit  m_over = 0;
    int  m_cnt = 0;
    string tag = "R9";

    always #10 clk = ~clk;

    disp_hold_reg i_disp_hold_reg (
        .clk(clk), .rst_n(rst_n), .res_valid_i(res_valid_i),
        .res_value_i(res_value_i), .res_ovr_i(res_ovr_i),
        .hold_i(hold_i), .peak_en_i(peak_en_i),
        .disp_value_o(disp_value_o), .disp_ovr_o(disp_ovr_o),
        .eoc_n_o(eoc_n_o), .under_o(under_o), .over_o(over_o)
    );

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_val = 0; m_ovr = 0; m_under = 0; m_over = 0; m_cnt = 0;
        end else begin
            if (res_valid_i) begin
                int  v;
                bit  big;
                bit  take;
                v   = int'(res_value_i);
                big = res_ovr_i || iabs(v) > 3999;
                m_over  = big;
                m_under = !big && iabs(v) <= 380;
                if (hold_i) take = 0;
                else if (!peak_en_i) take = 1;
                else if (m_ovr) take = 0;
                else if (big) take = 1;
                else take = iabs(v) > iabs(m_val);
                if (take) begin
                    m_ovr = big;
                    m_val = big ? 0 : v;
                end
                m_cnt = 10;
            end else if (m_cnt > 0) begin
                m_cnt = m_cnt - 1;
            end
        end
    end

    task automatic cmp(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            cmp(tag, "display value", int'(disp_value_o), m_val);
            cmp(tag, "display overload", int'(disp_ovr_o), int'(m_ovr));
            cmp("R1", "eoc_n", int'(eoc_n_o), int'(m_cnt == 0));
            cmp("R7", "under flag", int'(under_o), int'(m_under));
            cmp("R8", "over flag", int'(over_o), int'(m_over));
        end
    end

    task automatic conv(int v, bit ov);
        @(negedge clk);
        res_value_i = W'(v);
        res_ovr_i   = ov;
        res_valid_i = 1'b1;
        @(negedge clk);
        res_valid_i = 1'b0;
        res_ovr_i   = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2 normal loads, R7 boundaries
        tag = "R2";
        conv(1234, 0);
        conv(-2500, 0);
        conv(380, 0);
        conv(381, 0);
        conv(-380, 0);
        conv(3999, 0);
        // R6 overload by magnitude and by flag
        tag = "R6";
        conv(4000, 0);
        conv(100, 1);
        tag = "R2";
        conv(-700, 0);
        // R3 freeze: flags keep updating
        tag = "R3";
        hold_i = 1'b1;
        conv(50, 0);
        conv(3000, 0);
        conv(0, 1);
        hold_i = 1'b0;
        conv(200, 0);
        // R5 start peak from shown value 200
        tag = "R5";
        peak_en_i = 1'b1;
        conv(150, 0);
        // R4 peak comparisons
        tag = "R4";
        conv(-200, 0);
        conv(-900, 0);
        conv(899, 0);
        conv(901, 0);
        conv(-20, 0);
        // R6 overload beats numbers and stays
        tag = "R6";
        conv(0, 1);
        conv(3999, 0);
        conv(5, 0);
        // R5 leaving peak resumes normal loads
        tag = "R5";
        peak_en_i = 1'b0;
        conv(-15, 0);
        // R3 freeze inside peak mode
        tag = "R3";
        peak_en_i = 1'b1;
        hold_i = 1'b1;
        conv(2222, 0);
        hold_i = 1'b0;
        peak_en_i = 1'b0;
        // R9 reset mid-run
        tag = "R9";
        conv(777, 0);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        tag = "R2";
        conv(-1, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule